// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block forms physical byte addresses the way a 16-bit real-mode processor does. A segment value is scaled by sixteen, so every segment starts on a 16-byte paragraph boundary. An unsigned 16-bit offset is then added, which gives each segment a 64 KB window. Four segment registers are held locally: code, data, stack and extra. A write port loads them, and a translation request names one of them by a 2-bit select.

A translation request is accepted on any cycle. Its 21-bit result comes back exactly one clock later, and requests may follow each other on every cycle. The gate input `a20_enable` sets how the top carry is handled. When it is low, bit 20 is forced to zero, so sums that pass 1 MB wrap back to the bottom of memory. When it is high, the true carry passes through, and addresses up to 64 KB minus 16 bytes beyond 1 MB can be reached. No limit, protection or alias check is made: any segment:offset pair is translated without a fault.

Top module: `rmseg_addr_gen`

## Requirements
- R1: The segment base is the 16-bit segment value shifted left by four bits (segment x 16). A request with offset 0000h returns that base.
- R2: The result is the base plus the zero-extended 16-bit offset. Segment 000Ch with offset 000Fh gives 000CFh. The low four address bits always equal the low four offset bits.
- R3: While `a20_enable` is low in the request cycle, bit 20 of the result is 0, so sums of 2^20 or more wrap. FFFFh:0010h gives 00000h, FFFDh:03E8h gives 003B8h, and FFFFh:FFFFh gives 0FFEFh.
- R4: While `a20_enable` is high in the request cycle, the full 21-bit sum is returned. FFFFh:0010h gives 100000h and FFFFh:FFFFh gives 10FFEFh, which is the largest possible result.
- R5: No fault or bounds check exists. Different segment:offset pairs that name the same byte return the same address (0000h:00CFh equals 000Ch:000Fh).
- R6: `resp_valid` is high in exactly the cycle after each cycle in which `req_valid` was high, and low otherwise. Requests on consecutive cycles each get their own result.
- R7: Reset (`rst_n` low, asynchronous assert, synchronized release) clears all four segment registers to 0000h and drives `resp_valid` and `resp_addr` to 0.
- R8: A write (`wr_en` high, `wr_sel`, `wr_data`) updates the selected register at the next clock edge. A request in the same cycle that selects that register already uses `wr_data`.
- R9: Select encoding: 0 is code, 1 is data, 2 is stack, 3 is extra. A write changes only the selected register.
- R10: In a cycle that follows one without a request, `resp_addr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Register to write (0 code, 1 data, 2 stack, 3 extra) |
| wr_data | input | 16 | New segment value |
| a20_enable | input | 1 | High passes the carry into bit 20, low wraps at 1 MB |
| req_valid | input | 1 | Translation request strobe |
| req_sel | input | 2 | Segment register used by the request |
| req_offset | input | 16 | Unsigned offset within the segment |
| resp_valid | output | 1 | Result valid, one cycle after the request |
| resp_addr | output | 21 | Physical byte address |

## Verification
The bench aims at the carry out of the top of the 20-bit space. It runs the wrap cases FFFFh:0010h and FFFDh:03E8h with the gate closed and open. A design that ignored the gate would return 100000h where 0 is due, and one that always masked would never reach 10FFEFh. A request that reads a register in the same cycle it is written shows whether the bypass exists: without it the old value comes back. A write to one register followed by reads of the others catches a decoder that writes the wrong register. Idle gaps between back-to-back bursts expose a valid flag that sticks or a result register that changes without a request. A long pseudo-random run compares every result against the bench's own model of the four registers.

// File: rtl/rmseg_pkg.sv
package rmseg_pkg;
  localparam int DEF_SEG_W      = 16;
  localparam int DEF_OFS_W      = 16;
  localparam int DEF_PARA_SHIFT = 4;
  localparam int DEF_NUM_SEGS   = 4;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;
endpackage

// File: rtl/rmseg_rst_sync.sv
module rmseg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rmseg_seg_bank.sv
module rmseg_seg_bank #(
  parameter int SEG_W    = 16,
  parameter int NUM_SEGS = 4,
  localparam int SEL_W   = $clog2(NUM_SEGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [SEG_W-1:0] rd_data
);
  logic [NUM_SEGS-1:0][SEG_W-1:0] seg_all;

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    logic             load;
    logic [SEG_W-1:0] val_q;

    always_comb begin
      load = wr_en && (wr_sel == SEL_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val_q <= '0;
      else if (load) val_q <= wr_data;
    end

    assign seg_all[g] = val_q;
  end

  // read with same-cycle write bypass
  always_comb begin
    rd_data = seg_all[rd_sel];
    if (wr_en && (wr_sel == rd_sel)) rd_data = wr_data;
  end
endmodule

// File: rtl/rmseg_para_adder.sv
module rmseg_para_adder #(
  parameter int SEG_W      = 16,
  parameter int OFS_W      = 16,
  parameter int PARA_SHIFT = 4,
  localparam int PA_W      = SEG_W + PARA_SHIFT + 1
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFS_W-1:0] ofs,
  input  logic             a20_open,
  output logic [PA_W-1:0]  phys
);
  logic [PA_W-1:0] base_ext;
  logic [PA_W-1:0] ofs_ext;
  logic [PA_W-1:0] sum;

  always_comb begin
    base_ext = PA_W'({seg, {PARA_SHIFT{1'b0}}});
    ofs_ext  = PA_W'(ofs);
    sum      = base_ext + ofs_ext;
    // top bit is the carry past the legacy space; gate it
    phys     = {sum[PA_W-1] & a20_open, sum[PA_W-2:0]};
  end
endmodule

// File: rtl/rmseg_resp_stage.sv
module rmseg_resp_stage #(
  parameter int PA_W = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [PA_W-1:0] addr_in,
  output logic            resp_valid,
  output logic [PA_W-1:0] resp_addr
);
  logic            valid_d;
  logic [PA_W-1:0] addr_d;
  logic            addr_en;

  always_comb begin
    valid_d = req_valid;
    addr_en = req_valid;
    addr_d  = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_valid <= 1'b0;
    else        resp_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       resp_addr <= '0;
    else if (addr_en) resp_addr <= addr_d;
  end
endmodule

// File: rtl/rmseg_addr_gen.sv
module rmseg_addr_gen #(
  parameter int SEG_W      = rmseg_pkg::DEF_SEG_W,
  parameter int OFS_W      = rmseg_pkg::DEF_OFS_W,
  parameter int PARA_SHIFT = rmseg_pkg::DEF_PARA_SHIFT,
  parameter int NUM_SEGS   = rmseg_pkg::DEF_NUM_SEGS,
  localparam int SEL_W     = $clog2(NUM_SEGS),
  localparam int PA_W      = SEG_W + PARA_SHIFT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic             a20_enable,
  input  logic             req_valid,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [OFS_W-1:0] req_offset,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_addr
);
  logic             rst_n_sync;
  logic [SEG_W-1:0] seg_val;
  logic [PA_W-1:0]  phys_addr;

  rmseg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  rmseg_seg_bank #(.SEG_W(SEG_W), .NUM_SEGS(NUM_SEGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (req_sel),
    .rd_data (seg_val)
  );

  rmseg_para_adder #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PARA_SHIFT(PARA_SHIFT)) u_adder (
    .seg      (seg_val),
    .ofs      (req_offset),
    .a20_open (a20_enable),
    .phys     (phys_addr)
  );

  rmseg_resp_stage #(.PA_W(PA_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .req_valid  (req_valid),
    .addr_in    (phys_addr),
    .resp_valid (resp_valid),
    .resp_addr  (resp_addr)
  );
endmodule

// File: rtl/rmseg_addr_gen_chk.sv
module rmseg_addr_gen_chk #(
  parameter int SEG_W      = 16,
  parameter int OFS_W      = 16,
  parameter int PARA_SHIFT = 4,
  localparam int PA_W      = SEG_W + PARA_SHIFT + 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic [PARA_SHIFT-1:0] req_ofs_lo,
  input logic                  a20_enable,
  input logic                  resp_valid,
  input logic [PA_W-1:0]       resp_addr
);
  localparam int unsigned MAX_I =
    ((2**SEG_W - 1) * (2**PARA_SHIFT)) + (2**OFS_W - 1);

  // R6: a request is answered in the next cycle
  a_r6_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  // R6: no result without a request
  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  // R2: paragraph alignment leaves the offset's low bits untouched
  a_r2_low_bits_from_offset: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_addr[PARA_SHIFT-1:0] == $past(req_ofs_lo)));

  // R3: closed gate never yields an address at or above 1 MB
  a_r3_wrap_clears_top: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(a20_enable) || !resp_addr[PA_W-1]));

  // R4: no result exceeds the top segment plus the largest offset
  a_r4_max_addr: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_addr <= PA_W'(MAX_I)));

  // R10: result register holds across idle cycles
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(resp_addr));

  // R7: leaving reset, no result is pending
  a_r7_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (!resp_valid && (resp_addr == '0)));
endmodule

bind rmseg_addr_gen rmseg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFS_W(OFS_W), .PARA_SHIFT(PARA_SHIFT)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .req_valid  (req_valid),
  .req_ofs_lo (req_offset[PARA_SHIFT-1:0]),
  .a20_enable (a20_enable),
  .resp_valid (resp_valid),
  .resp_addr  (resp_addr)
);

// File: tb/rmseg_addr_gen_tb_top.sv
module rmseg_addr_gen_tb_top;
  import rmseg_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic        a20_enable;
  logic        req_valid;
  logic [1:0]  req_sel;
  logic [15:0] req_offset;
  logic        resp_valid;
  logic [20:0] resp_addr;

  always #10 clk = ~clk;  // 50 MHz

  rmseg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .a20_enable(a20_enable), .req_valid(req_valid), .req_sel(req_sel),
    .req_offset(req_offset), .resp_valid(resp_valid), .resp_addr(resp_addr)
  );

  typedef struct {
    logic [20:0] addr;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] mseg [4];
  int          total = 0;
  int          bad   = 0;
  bit          active = 0;
  bit          finished = 0;
  logic [20:0] last_addr = '0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [20:0] act, input logic [20:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [20:0] model(input logic [15:0] s, input logic [15:0] o,
                                        input logic a20);
    logic [20:0] r;
    r = {1'b0, s, 4'h0} + {5'h0, o};
    if (!a20) r[20] = 1'b0;
    return r;
  endfunction

  // driver: one cycle of stimulus, optional write and optional request
  task automatic cyc(input bit rv, input logic [1:0] rs, input logic [15:0] ro,
                     input logic a20, input bit wv, input logic [1:0] ws,
                     input logic [15:0] wd, input string tag);
    exp_t        e;
    logic [15:0] sv;
    @(negedge clk);
    req_valid = rv; req_sel = rs; req_offset = ro; a20_enable = a20;
    wr_en = wv; wr_sel = ws; wr_data = wd;
    if (rv) begin
      sv = (wv && ws == rs) ? wd : mseg[rs];
      e.addr = model(sv, ro, a20);
      e.tag  = tag;
      sb.push_back(e);
    end
    if (wv) mseg[ws] = wd;
  endtask

  task automatic req(input logic [1:0] rs, input logic [15:0] ro, input logic a20,
                     input string tag);
    cyc(1'b1, rs, ro, a20, 1'b0, 2'd0, 16'h0, tag);
  endtask

  task automatic wr(input logic [1:0] ws, input logic [15:0] wd);
    cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b1, ws, wd, "");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 2'd0, 16'h0, "");
  endtask

  // monitor: scoreboard compare shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (active && !finished) begin
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(resp_valid === 1'b1, "R6", "resp_valid after request", 21'(resp_valid), 21'd1);
        check(resp_addr === e.addr, e.tag, "resp_addr", resp_addr, e.addr);
        last_addr = resp_addr;
      end else begin
        check(resp_valid === 1'b0, "R6", "resp_valid when idle", 21'(resp_valid), 21'd0);
        check(resp_addr === last_addr, "R10", "resp_addr hold", resp_addr, last_addr);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R6 watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 4; i++) mseg[i] = 16'h0;
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0;
    a20_enable = 0; req_valid = 0; req_sel = 0; req_offset = 0;
    repeat (3) @(negedge clk);
    // R7: outputs cleared during reset
    check(resp_valid === 1'b0, "R7", "resp_valid in reset", 21'(resp_valid), 21'd0);
    check(resp_addr === 21'h0, "R7", "resp_addr in reset", resp_addr, 21'h0);
    rst_n = 1'b1;
    idle(4);
    active = 1;

    // R7: every register reads zero after reset
    req(SEG_CODE,  16'h0000, 1'b0, "R7");
    req(SEG_DATA,  16'h0000, 1'b0, "R7");
    req(SEG_STACK, 16'h0000, 1'b0, "R7");
    req(SEG_EXTRA, 16'h0000, 1'b1, "R7");
    idle(2);

    // R1 / R2
    wr(SEG_CODE, 16'h000C);
    req(SEG_CODE, 16'h0000, 1'b0, "R1");
    req(SEG_CODE, 16'h000F, 1'b0, "R2");
    wr(SEG_DATA, 16'h1234);
    req(SEG_DATA, 16'h0000, 1'b0, "R1");
    req(SEG_DATA, 16'h5678, 1'b0, "R2");
    // R9: the data write left code untouched, stack and extra still zero
    req(SEG_CODE,  16'h0000, 1'b0, "R9");
    req(SEG_STACK, 16'h0001, 1'b0, "R9");
    req(SEG_EXTRA, 16'h0002, 1'b0, "R9");
    idle(3);

    // R3: wrap with gate closed
    wr(SEG_STACK, 16'hFFFF);
    wr(SEG_EXTRA, 16'hFFFD);
    req(SEG_STACK, 16'h0010, 1'b0, "R3");
    req(SEG_EXTRA, 16'h03E8, 1'b0, "R3");
    req(SEG_STACK, 16'hFFFF, 1'b0, "R3");
    // R4: gate open
    req(SEG_STACK, 16'h0010, 1'b1, "R4");
    req(SEG_STACK, 16'hFFFF, 1'b1, "R4");
    req(SEG_EXTRA, 16'h03E8, 1'b1, "R4");
    req(SEG_STACK, 16'h000F, 1'b1, "R4");
    idle(2);

    // R5: aliasing pairs agree
    wr(SEG_EXTRA, 16'h0000);
    req(SEG_EXTRA, 16'h00CF, 1'b0, "R5");
    req(SEG_CODE,  16'h000F, 1'b0, "R5");
    idle(1);

    // R8: same-cycle bypass, then registered value
    cyc(1'b1, SEG_DATA, 16'h0005, 1'b0, 1'b1, SEG_DATA, 16'hABCD, "R8");
    req(SEG_DATA, 16'h0000, 1'b0, "R8");
    // R9: write to another register during a request
    cyc(1'b1, SEG_DATA, 16'h0001, 1'b0, 1'b1, SEG_CODE, 16'h4444, "R9");
    req(SEG_CODE, 16'h0000, 1'b0, "R9");
    idle(3);

    // R6 / R10: mixed pseudo-random traffic with gaps
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr;
      cyc(a[0] | a[1], b[1:0], {a[15:4], b[15:12]}, a[2], a[3], a[5:4],
          {b[11:0], a[15:12]}, "R6");
    end
    idle(3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule